// File: doc/BRIEF.md
# Gate-Source Voltage Fault Monitor

This block supervises the external switches of three half-bridges, one channel per gate (six in all). For every channel it takes the commanded gate level and a digitized comparator output that reports whether the measured gate-source voltage is above its threshold. When the two disagree for long enough, the block records a fault for that channel. A commanded-off switch whose gate stays above threshold is a fault, and so is a commanded-on switch whose gate stays below threshold.

Each change of the command opens a blanking window that covers the expected switching transition. No mismatch is counted during that window. After the window closes, a deglitch counter measures how long a mismatch lasts. Only a mismatch that outlives the deglitch time sets the channel's sticky flag and pulls the shared active-low fault output low. Both windows come from 2-bit selectors and are counted in clock cycles, scaled by a cycles-per-microsecond parameter. The blanking selector is meant to be shared with a drain-source monitor alongside this block. Command and comparator inputs are asynchronous and pass through two-flop synchronizers.

Top module: `vgs_fault_monitor`

## Requirements
- R1: With the command held low, a comparator reading of 1 (above threshold) that persists sets that channel's flag.
- R2: With the command held high, a comparator reading of 0 (below threshold) that persists sets that channel's flag.
- R3: Once blanking is over, a flag is set only after the mismatch has been seen on D+1 consecutive synchronized samples, where D is the deglitch length in cycles. Shorter mismatches leave the flags unchanged.
- R4: Bit i of the flag vector reports channel i only. A set bit stays set after the mismatch disappears.
- R5: The fault output is low exactly when at least one flag is set, and it changes on the same clock edge as the flags.
- R6: The blanking selector values 0, 1, 2 and 3 give C/2, C, 2C and 4C cycles, where C is the cycles per microsecond. No deglitch counting takes place during that many cycles after each synchronized command change.
- R7: The deglitch selector values 0, 1, 2 and 3 give D = C/4, C/2, C and 2C cycles (integer division).
- R8: A command change that arrives during blanking or deglitching reloads the full blanking window and zeroes the deglitch count.
- R9: The deglitch count returns to zero on any sample without a mismatch, so interrupted mismatches never accumulate.
- R10: Inputs are seen through two flip-flops. A comparator change made before clock edge k first counts as a mismatch sample at edge k+2.
- R11: A clear pulse empties all flags. The only exception is a channel that trips in that same cycle: setting wins over clearing.
- R12: Synchronous reset empties the flags, drives the fault output high and restarts all channels without blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_cmd | input | 6 | Commanded gate level per channel (1 = on) |
| vgs_above | input | 6 | Comparator per channel, 1 when gate-source voltage is above threshold |
| blank_sel | input | 2 | Blanking length selector |
| degl_sel | input | 2 | Deglitch length selector |
| flag_clr | input | 1 | One-cycle pulse that clears the sticky flags |
| flags | output | 6 | Sticky per-channel fault flags |
| fault_n | output | 1 | Active-low fault, low while any flag is set |

## Verification
The assertions assume the two selectors only change while the channels are idle. A selector change in mid-window makes the cycle counts ambiguous. The bench therefore changes configuration only at phase boundaries. The assertions also assume the clear input is a level sampled every cycle. The stimulus drives it as isolated single-cycle pulses, and drives every input on the falling clock edge so that each value is captured cleanly by the first synchronizer stage.

// File: rtl/vgs_mon_pkg.sv
package vgs_mon_pkg;

  // Blanking length in cycles for a 2-bit selector.
  function automatic int unsigned blank_cycles(input logic [1:0] sel, input int unsigned cpu);
    case (sel)
      2'd0:    return cpu / 2;
      2'd1:    return cpu;
      2'd2:    return cpu * 2;
      default: return cpu * 4;
    endcase
  endfunction

  // Deglitch length in cycles for a 2-bit selector.
  function automatic int unsigned degl_cycles(input logic [1:0] sel, input int unsigned cpu);
    case (sel)
      2'd0:    return cpu / 4;
      2'd1:    return cpu / 2;
      2'd2:    return cpu;
      default: return cpu * 2;
    endcase
  endfunction

endpackage

// File: rtl/vgs_sync.sv
module vgs_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/vgs_chan.sv
module vgs_chan #(
  parameter int CYC_PER_US = 125,
  parameter int CNT_W      = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd,
  input  logic       sense,
  input  logic [1:0] blank_sel,
  input  logic [1:0] degl_sel,
  output logic       trip,
  output logic       blank_done
);
  logic             cmd_q;
  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] dcnt;
  logic [CNT_W-1:0] b_len;
  logic [CNT_W-1:0] d_len;
  logic             cmd_chg;
  logic             mism;
  logic             d_full;

  always_comb begin
    b_len      = CNT_W'(vgs_mon_pkg::blank_cycles(blank_sel, CYC_PER_US));
    d_len      = CNT_W'(vgs_mon_pkg::degl_cycles(degl_sel, CYC_PER_US));
    cmd_chg    = cmd ^ cmd_q;
    mism       = cmd ^ sense;
    blank_done = (bcnt == '0);
    d_full     = (dcnt == d_len);
    trip       = blank_done & ~cmd_chg & mism & d_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= 1'b0;
      bcnt  <= '0;
      dcnt  <= '0;
    end else begin
      cmd_q <= cmd;
      if (cmd_chg) begin
        bcnt <= b_len;
        dcnt <= '0;
      end else if (!blank_done) begin
        bcnt <= bcnt - 1'b1;
        dcnt <= '0;
      end else if (mism) begin
        if (!d_full) dcnt <= dcnt + 1'b1;
      end else begin
        dcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/vgs_flag_reg.sv
module vgs_flag_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] trip,
  input  logic         clr,
  output logic [W-1:0] flags,
  output logic         fault_n
);
  logic [W-1:0] flags_nxt;

  always_comb begin
    flags_nxt = clr ? trip : (flags | trip);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      fault_n <= 1'b1;
    end else begin
      flags   <= flags_nxt;
      fault_n <= ~|flags_nxt;
    end
  end
endmodule

// File: rtl/vgs_fault_monitor.sv
module vgs_fault_monitor #(
  parameter int NUM_CH     = 6,
  parameter int CYC_PER_US = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] gate_cmd,
  input  logic [NUM_CH-1:0] vgs_above,
  input  logic [1:0]        blank_sel,
  input  logic [1:0]        degl_sel,
  input  logic              flag_clr,
  output logic [NUM_CH-1:0] flags,
  output logic              fault_n
);
  localparam int MAX_CYC = 4 * CYC_PER_US;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [NUM_CH-1:0] cmd_s;
  logic [NUM_CH-1:0] sense_s;
  logic [NUM_CH-1:0] trip_v;
  logic [NUM_CH-1:0] blank_done_v;

  vgs_sync #(.W(NUM_CH)) u_sync_cmd (
    .clk(clk), .rst(rst), .d_async(gate_cmd), .d_sync(cmd_s)
  );

  vgs_sync #(.W(NUM_CH)) u_sync_sense (
    .clk(clk), .rst(rst), .d_async(vgs_above), .d_sync(sense_s)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    vgs_chan #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_chan (
      .clk(clk),
      .rst(rst),
      .cmd(cmd_s[g]),
      .sense(sense_s[g]),
      .blank_sel(blank_sel),
      .degl_sel(degl_sel),
      .trip(trip_v[g]),
      .blank_done(blank_done_v[g])
    );
  end

  vgs_flag_reg #(.W(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .trip(trip_v), .clr(flag_clr),
    .flags(flags), .fault_n(fault_n)
  );
endmodule

// File: rtl/vgs_fault_monitor_chk.sv
module vgs_fault_monitor_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              flag_clr,
  input logic [NUM_CH-1:0] flags,
  input logic              fault_n,
  input logic [NUM_CH-1:0] trip_v,
  input logic [NUM_CH-1:0] blank_done_v
);
  // R12
  reset_state_chk: assert property (@(posedge clk) rst |=> (flags == '0 && fault_n));

  // R5
  pin_low_chk: assert property (@(posedge clk) disable iff (rst) (flags != '0) |-> !fault_n);

  // R5
  pin_high_chk: assert property (@(posedge clk) disable iff (rst) (flags == '0) |-> fault_n);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(flag_clr) |-> ((flags & $past(flags)) == $past(flags)));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && trip_v == '0) |=> (flags == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_chk
    // R6
    after_blank_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[g]) |-> $past(blank_done_v[g]));

    // R4
    trip_sets_chk: assert property (@(posedge clk) disable iff (rst)
      trip_v[g] |=> flags[g]);
  end
endmodule

bind vgs_fault_monitor vgs_fault_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk),
  .rst(rst),
  .flag_clr(flag_clr),
  .flags(flags),
  .fault_n(fault_n),
  .trip_v(trip_v),
  .blank_done_v(blank_done_v)
);

// File: tb/vgs_fault_monitor_tb.sv
module vgs_fault_monitor_tb;
  localparam int NCH = 6;
  localparam int CPU = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] gate_cmd = '0;
  logic [NCH-1:0] vgs_above = '0;
  logic [1:0]     blank_sel = 2'd0;
  logic [1:0]     degl_sel = 2'd0;
  logic           flag_clr = 1'b0;
  logic [NCH-1:0] flags;
  logic           fault_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vgs_fault_monitor #(.NUM_CH(NCH), .CYC_PER_US(CPU)) u_dut (
    .clk(clk), .rst(rst), .gate_cmd(gate_cmd), .vgs_above(vgs_above),
    .blank_sel(blank_sel), .degl_sel(degl_sel), .flag_clr(flag_clr),
    .flags(flags), .fault_n(fault_n)
  );

  // Behavioural reference
  int m_c1[NCH], m_c2[NCH], m_v1[NCH], m_v2[NCH], m_prev[NCH];
  int m_bc[NCH], m_dc[NCH];
  int m_flags[NCH];
  int m_fault_n = 1;

  function automatic int blank_len(input int sel);
    int r;
    if (sel == 0) r = CPU / 2;
    else if (sel == 1) r = CPU;
    else if (sel == 2) r = 2 * CPU;
    else r = 4 * CPU;
    return r;
  endfunction

  function automatic int degl_len(input int sel);
    int r;
    if (sel == 0) r = CPU / 4;
    else if (sel == 1) r = CPU / 2;
    else if (sel == 2) r = CPU;
    else r = 2 * CPU;
    return r;
  endfunction

  always @(posedge clk) begin
    int any;
    int hits[NCH];
    any = 0;
    for (int c = 0; c < NCH; c++) begin
      hits[c] = 0;
      if (rst) begin
        m_c1[c] = 0; m_c2[c] = 0; m_v1[c] = 0; m_v2[c] = 0; m_prev[c] = 0;
        m_bc[c] = 0; m_dc[c] = 0; m_flags[c] = 0;
      end else begin
        if (m_c2[c] != m_prev[c]) begin
          m_bc[c] = blank_len(blank_sel);
          m_dc[c] = 0;
        end else if (m_bc[c] > 0) begin
          m_bc[c] = m_bc[c] - 1;
          m_dc[c] = 0;
        end else if (m_c2[c] != m_v2[c]) begin
          if (m_dc[c] == degl_len(degl_sel)) hits[c] = 1;
          else m_dc[c] = m_dc[c] + 1;
        end else begin
          m_dc[c] = 0;
        end
        m_prev[c] = m_c2[c];
        m_c2[c] = m_c1[c];
        m_v2[c] = m_v1[c];
        m_c1[c] = gate_cmd[c];
        m_v1[c] = vgs_above[c];
        if (flag_clr) m_flags[c] = hits[c];
        else if (hits[c] != 0) m_flags[c] = 1;
      end
      if (m_flags[c] != 0) any = 1;
    end
    m_fault_n = any ? 0 : 1;
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        vectors++;
        if (int'(flags[c]) != m_flags[c]) begin
          miscompares++;
          $display("FAIL R4 model flag ch%0d: actual %0d expected %0d at %0t", c, flags[c], m_flags[c], $time);
        end
      end
      vectors++;
      if (int'(fault_n) != m_fault_n) begin
        miscompares++;
        $display("FAIL R5 model fault_n: actual %0d expected %0d at %0t", fault_n, m_fault_n, $time);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    tick(1);
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int b, d;
    tick(3);
    // R12 reset state
    check(flags == '0, "R12 flags in reset", int'(flags), 0);
    check(fault_n == 1'b1, "R12 fault_n in reset", int'(fault_n), 1);
    rst = 1'b0;
    tick(20);
    check(flags == '0, "R12 quiet after reset", int'(flags), 0);

    // R2: ch0 commanded on, gate stays low. B=4, D=2 -> trip after 4+B+D edges
    b = blank_len(0); d = degl_len(0);
    gate_cmd[0] = 1'b1;
    tick(3 + b + d);
    check(flags[0] == 1'b0, "R2/R6 ch0 not yet", int'(flags[0]), 0);
    tick(1);
    check(flags[0] == 1'b1, "R2 ch0 flagged", int'(flags[0]), 1);
    check(flags[NCH-1:1] == '0, "R4 only ch0", int'(flags), 1);
    check(fault_n == 1'b0, "R5 fault_n low", int'(fault_n), 0);
    vgs_above[0] = 1'b1;
    tick(10);
    check(flags[0] == 1'b1, "R4 sticky ch0", int'(flags[0]), 1);
    clear_flags();
    check(flags == '0, "R11 cleared", int'(flags), 0);
    check(fault_n == 1'b1, "R5 fault_n released", int'(fault_n), 1);

    // R1 / R10: ch3 off, gate goes high, no command edge -> trip after 3+D edges
    vgs_above[3] = 1'b1;
    tick(2 + d);
    check(flags[3] == 1'b0, "R10 ch3 not yet", int'(flags[3]), 0);
    tick(1);
    check(flags[3] == 1'b1, "R1 ch3 flagged", int'(flags[3]), 1);
    vgs_above[3] = 1'b0;
    tick(2);
    // R11: clear while ch4 is tripping keeps ch4
    vgs_above[4] = 1'b1;
    tick(3 + d);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    check(flags[4] == 1'b1, "R11 set wins over clear", int'(flags[4]), 1);
    check(flags[3] == 1'b0, "R11 ch3 cleared", int'(flags[3]), 0);
    vgs_above[4] = 1'b0;
    tick(3);
    clear_flags();

    // R3: pulse of D samples ignored, D+1 samples trips
    vgs_above[4] = 1'b1; tick(d); vgs_above[4] = 1'b0;
    tick(10);
    check(flags[4] == 1'b0, "R3 short glitch ignored", int'(flags[4]), 0);
    vgs_above[4] = 1'b1; tick(d + 1); vgs_above[4] = 1'b0;
    tick(10);
    check(flags[4] == 1'b1, "R3 long glitch flagged", int'(flags[4]), 1);
    clear_flags();

    // R8: ch5 toggles faster than blanking, gate stays low
    for (int i = 0; i < 14; i++) begin
      gate_cmd[5] = ~gate_cmd[5];
      tick(3);
    end
    check(flags[5] == 1'b0, "R8 edges restart blanking", int'(flags[5]), 0);
    gate_cmd[5] = 1'b0;
    tick(10);
    clear_flags();

    // R6/R7 longest setting on ch2
    blank_sel = 2'd3; degl_sel = 2'd3;
    b = blank_len(3); d = degl_len(3);
    tick(2);
    gate_cmd[2] = 1'b1;
    tick(3 + b + d);
    check(flags[2] == 1'b0, "R6/R7 ch2 not yet", int'(flags[2]), 0);
    tick(1);
    check(flags[2] == 1'b1, "R7 ch2 flagged at 4C+2C", int'(flags[2]), 1);
    gate_cmd[2] = 1'b0;
    tick(b + 5);
    clear_flags();

    // R9: interrupted mismatches do not accumulate
    vgs_above[1] = 1'b1; tick(10);
    vgs_above[1] = 1'b0; tick(1);
    vgs_above[1] = 1'b1; tick(10);
    vgs_above[1] = 1'b0;
    tick(5);
    check(flags[1] == 1'b0, "R9 counter reset on gap", int'(flags[1]), 0);

    // Sweep all configurations against the reference
    for (int cfg = 0; cfg < 16; cfg++) begin
      blank_sel = 2'(cfg >> 2);
      degl_sel = 2'(cfg & 3);
      for (int n = 0; n < 300; n++) begin
        for (int c = 0; c < NCH; c++) begin
          if ($urandom_range(0, 39) == 0) gate_cmd[c] = ~gate_cmd[c];
          if ($urandom_range(0, 9) == 0) vgs_above[c] = ~vgs_above[c];
        end
        flag_clr = ($urandom_range(0, 59) == 0);
        tick(1);
      end
      flag_clr = 1'b0;
      gate_cmd = '0;
      vgs_above = '0;
      tick(80);
    end

    // R12 reset mid-run
    gate_cmd[0] = 1'b1;
    tick(60);
    rst = 1'b1;
    tick(2);
    check(flags == '0, "R12 reset clears flags", int'(flags), 0);
    check(fault_n == 1'b1, "R12 reset releases fault_n", int'(fault_n), 1);
    rst = 1'b0;
    tick(5);
    finish_run();
  end
endmodule